// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Postscaler

This block watches for a stalled processor. A slow internal oscillator reaches it as a one-cycle tick enable on the system clock. A fixed prescaler divides those ticks into a base period. A postscaler then stretches that period by a power of two, picked by a 4-bit select field. With the default prescale of 128 and a nominal oscillator, the base period is about 4 ms, and the longest setting is about 131 s.

Four events restart the count from zero: a clear command from software, entry into sleep, a flagged oscillator failure, and device reset. If the count is not restarted in time it expires. When the device is running, expiry gives a one-cycle reset request. When the device is asleep, expiry gives a one-cycle wake-up pulse instead. A sticky flag records which of the two happened last.

The watchdog runs when the configuration enable is set. When the configuration enable is off, the software enable bit decides instead. While the watchdog is disabled, both counters stay at zero and nothing is produced.

Top module: `wdt_postscale`

## Requirements
- R1: After reset, `rst_req`, `wake_pulse` and `wake_flag` are 0 and the count starts from zero.
- R2: Only cycles with `osc_tick` high advance the count. One base period is PRESCALE ticks, and PRESCALE must be at least 2.
- R3: Expiry happens on the edge that takes the PRESCALE·2^n-th tick since the last restart, where n is the latched 4-bit select code. Code 0 gives 1:1 and code 15 gives 1:32768. The output pulse is visible in the cycle after that edge.
- R4: A cycle with `clear_cmd` high restarts the count from zero, and no pulse follows that cycle.
- R5: A cycle with `sleep_entry` high restarts the count from zero.
- R6: A cycle with `osc_fail` high restarts the count from zero.
- R7: The watchdog is enabled when `cfg_enable` or `sw_enable` is 1. While it is disabled, the count is held at zero and no pulse is produced.
- R8: Expiry with `asleep` low gives `rst_req` high for exactly one cycle, and no wake pulse.
- R9: Expiry with `asleep` high gives `wake_pulse` high for exactly one cycle, and no reset request.
- R10: `wake_flag` becomes 1 with every wake pulse and 0 with every reset request. Otherwise it holds its value.
- R11: `ratio_sel` is latched only on a restart cycle or a disabled cycle. A change in the middle of a count does not alter the current timeout.
- R12: After expiry the count restarts from zero, so an unserviced watchdog fires once every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous device reset |
| osc_tick | input | 1 | One-cycle tick from the slow oscillator |
| cfg_enable | input | 1 | Fixed configuration enable |
| sw_enable | input | 1 | Software enable, used when `cfg_enable` is 0 |
| clear_cmd | input | 1 | Clear-watchdog command |
| sleep_entry | input | 1 | Pulse when the device enters sleep |
| asleep | input | 1 | Device is in sleep or another power-managed mode |
| osc_fail | input | 1 | Primary or secondary oscillator failure |
| ratio_sel | input | SEL_W | Postscaler select code n, ratio 2^n |
| rst_req | output | 1 | One-cycle watchdog reset request |
| wake_pulse | output | 1 | One-cycle wake-up event |
| wake_flag | output | 1 | 1 if the last expiry was a wake-up |

## Verification
The bound checker tests a set of rules on every cycle:
- The two pulses are never high together, and each lasts one cycle.
- No pulse follows a cycle without a tick, a disabled cycle, or a clear cycle.
- A wake pulse follows only a sleeping cycle.
- The flag agrees with whichever pulse fired.

Some behaviours can only be shown by the bench's scenarios and its cycle-by-cycle reference model:
- The exact timeout length for several select codes, including the maximum.
- Restart by each of the clear sources.
- Periodic firing when the watchdog is left unserviced.
- Latching of the select code at a restart.
- The software enable taking over while the configuration enable is off.

// File: rtl/wdt_postscale.sv
module wdt_postscale #(
  parameter int PRESCALE = 128,
  parameter int SEL_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             cfg_enable,
  input  logic             sw_enable,
  input  logic             clear_cmd,
  input  logic             sleep_entry,
  input  logic             asleep,
  input  logic             osc_fail,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             rst_req,
  output logic             wake_pulse,
  output logic             wake_flag
);
  localparam int PRE_W  = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam int POST_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [SEL_W-1:0]  sel_q;

  wire              enabled  = cfg_enable | sw_enable;
  wire              restart  = !enabled | clear_cmd | sleep_entry | osc_fail;
  wire              base_end = osc_tick && (pre_cnt == PRE_W'(PRESCALE - 1));
  wire [POST_W-1:0] post_lim = ~({POST_W{1'b1}} << sel_q);
  wire              expire   = !restart && base_end && (post_cnt == post_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      sel_q    <= '0;
    end else if (restart) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      sel_q    <= ratio_sel;
    end else if (osc_tick) begin
      pre_cnt <= base_end ? '0 : pre_cnt + 1'b1;
      if (base_end)
        post_cnt <= expire ? '0 : post_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      wake_pulse <= 1'b0;
      wake_flag  <= 1'b0;
    end else begin
      rst_req    <= expire && !asleep;
      wake_pulse <= expire && asleep;
      if (expire) wake_flag <= asleep;
    end
  end
endmodule

// File: rtl/wdt_postscale_chk.sv
module wdt_postscale_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_tick,
  input logic             cfg_enable,
  input logic             sw_enable,
  input logic             clear_cmd,
  input logic             sleep_entry,
  input logic             asleep,
  input logic             osc_fail,
  input logic [SEL_W-1:0] ratio_sel,
  input logic             rst_req,
  input logic             wake_pulse,
  input logic             wake_flag
);
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(rst_req && wake_pulse)); // R8
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_req |=> !rst_req); // R8
  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wake_pulse |=> !wake_pulse); // R9
  AST_NO_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !osc_tick |=> !(rst_req || wake_pulse)); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_enable || sw_enable) |=> !(rst_req || wake_pulse)); // R7
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (clear_cmd || sleep_entry || osc_fail) |=> !(rst_req || wake_pulse)); // R4
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) wake_pulse |-> $past(asleep)); // R9
  AST_RST_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> !$past(asleep)); // R8
  AST_FLAG_WAKE: assert property (@(posedge clk) disable iff (!rst_n) wake_pulse |-> wake_flag); // R10
  AST_FLAG_RST: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> !wake_flag); // R10
endmodule

bind wdt_postscale wdt_postscale_chk #(.SEL_W(SEL_W)) chk_i (.*);

// File: tb/wdt_postscale_tb_top.sv
module wdt_postscale_tb_top;
  localparam int P = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, cfg_enable = 1'b0, sw_enable = 1'b0, clear_cmd = 1'b0;
  logic sleep_entry = 1'b0, asleep = 1'b0, osc_fail = 1'b0;
  logic [3:0] ratio_sel = '0;
  logic rst_req, wake_pulse, wake_flag;

  int errors = 0, checks = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  wdt_postscale #(.PRESCALE(P), .SEL_W(4)) dut_i (.*);

  int m_cnt = 0, m_sel = 0;
  bit m_rst = 0, m_wake = 0, m_flag = 0;

  always @(posedge clk) begin
    m_rst = 0; m_wake = 0;
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_flag = 0;
    end else if (!(cfg_enable || sw_enable) || clear_cmd || sleep_entry || osc_fail) begin
      m_cnt = 0; m_sel = ratio_sel;
    end else if (osc_tick) begin
      m_cnt++;
      if (m_cnt == (P << m_sel)) begin
        m_cnt = 0;
        if (asleep) begin m_wake = 1; m_flag = 1; end
        else begin m_rst = 1; m_flag = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check({rst_req, wake_pulse, wake_flag} == {m_rst, m_wake, m_flag}, phase,
          int'({rst_req, wake_pulse, wake_flag}), int'({m_rst, m_wake, m_flag}));
  end

  task automatic measure(input int sel, input string req);
    int n = 0;
    int exp = P << sel;
    ratio_sel = 4'(sel); clear_cmd = 1; osc_tick = 1;
    @(negedge clk); clear_cmd = 0;
    do begin @(negedge clk); n++; end while (!(rst_req || wake_pulse) && n < exp + 10);
    check(n == exp, req, n, exp);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({rst_req, wake_pulse, wake_flag} == 3'b000, "R1", int'({rst_req, wake_pulse, wake_flag}), 0);
    rst_n = 1;
    cfg_enable = 1;
    phase = "R2"; measure(0, "R2");
    phase = "R3"; measure(3, "R3");
    check(rst_req == 1, "R8", rst_req, 1);
    check(wake_flag == 0, "R10", wake_flag, 0);
    phase = "R12";
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!rst_req && n < 100);
      check(n == (P << 3), "R12", n, P << 3);
    end
    phase = "R4"; ratio_sel = 2; clear_cmd = 1; @(negedge clk); clear_cmd = 0; cycles(5);
    clear_cmd = 1; @(negedge clk); clear_cmd = 0; cycles(20);
    phase = "R5"; cycles(3); sleep_entry = 1; @(negedge clk); sleep_entry = 0; cycles(20);
    phase = "R6"; cycles(5); osc_fail = 1; @(negedge clk); osc_fail = 0; cycles(20);
    phase = "R9"; asleep = 1; measure(2, "R9");
    check(wake_pulse == 1 && rst_req == 0, "R9", int'({wake_pulse, rst_req}), 2);
    check(wake_flag == 1, "R10", wake_flag, 1);
    asleep = 0; phase = "R8"; measure(1, "R8");
    check(wake_flag == 0, "R10", wake_flag, 0);
    phase = "R11"; ratio_sel = 2; clear_cmd = 1; @(negedge clk); clear_cmd = 0; ratio_sel = 0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!rst_req && n < 100);
      check(n == (P << 2), "R11", n, P << 2);
    end
    phase = "R7"; cfg_enable = 0; sw_enable = 0;
    begin
      int pulses = 0;
      for (int i = 0; i < 60; i++) begin @(negedge clk); if (rst_req || wake_pulse) pulses++; end
      check(pulses == 0, "R7", pulses, 0);
    end
    sw_enable = 1; measure(1, "R7");
    phase = "R2";
    for (int i = 0; i < 200; i++) begin
      osc_tick = (i % 3 != 0); asleep = (i % 50 > 25); ratio_sel = 4'(i % 3);
      @(negedge clk);
    end
    osc_tick = 1; asleep = 0; cfg_enable = 1;
    phase = "R3"; measure(15, "R3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule